// File: doc/BRIEF.md
# Hash to queue ID distributor

This block turns a 64-bit flow hash into a 24-bit frame queue ID so that received traffic can be spread over a power-of-two group of queues. An upstream hash unit supplies the hash with a valid strobe. The block picks a 24-bit window out of it with a configurable right shift, keeps only the bits that fall inside the queue range, and ORs them onto a base queue ID. The result comes out one clock later with its own valid strobe.

Each scheme is described by a mode word, a base queue ID, a hash command word and two substitute key values. A scheme that is switched off does not produce queue IDs. Instead it flags each packet as unmatched so that a later stage can forward it unchanged. A configuration that breaks the range or base rules raises an error flag and blocks queue output. A small side path selects, for each of the two key fields, either the field extracted from the packet or the scheme's substitute value. The external hash unit then works on a key that is always complete.

Top module: `hash_qdist`

## Requirements
- R1: While reset is high and in the first cycle after it, out_vld, out_miss, cfg_err, out_qid, key_addr and key_port are all zero.
- R2: One cycle after in_vld is high on an enabled, valid scheme, out_vld is high and out_qid = base[23:0] | ((in_hash >> S)[23:0] & M). Here S is cfg_hcmd[29:24] and M is cfg_hcmd[23:0].
- R3: With S equal to zero, the window is the least significant 24 bits of the hash. With S = 63, only hash bit 63 can reach bit 0 of the window.
- R4: An all-zero hash command word sends every packet to the base queue ID, whatever the hash.
- R5: The symmetric-hash flag, cfg_hcmd bit 30, has no effect on out_qid.
- R6: When cfg_mode bit 31 is clear, in_vld gives out_miss high for exactly one cycle, one cycle later, and out_vld stays low. This holds even if the configuration is invalid.
- R7: cfg_err is high one cycle after the configuration meets any of these conditions: cfg_base[23:0] is zero, any of cfg_base[31:24] is set, or M is not of the form 2^k−1. While cfg_err is high, an enabled scheme produces neither out_vld nor out_miss.
- R8: One cycle after any input change, key_addr equals fld_addr when fld_addr_ok is high and cfg_dflt_addr otherwise. key_port is chosen the same way from fld_port, fld_port_ok and cfg_dflt_port.
- R9: out_vld and out_miss are never high together. Neither is high unless in_vld was high in the previous cycle, so back-to-back inputs give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 32 | Scheme mode word; bit 31 enables the scheme |
| cfg_base | input | 32 | Base queue ID; only bits 23:0 are legal |
| cfg_hcmd | input | 32 | Hash command: 29:24 shift, 30 symmetric flag, 23:0 range minus one |
| cfg_dflt_addr | input | 32 | Substitute value for an absent address field |
| cfg_dflt_port | input | 32 | Substitute value for an absent L4 port field |
| in_vld | input | 1 | Hash input valid |
| in_hash | input | 64 | Flow hash |
| fld_addr | input | 32 | Extracted address field |
| fld_addr_ok | input | 1 | Address field present |
| fld_port | input | 32 | Extracted L4 port field |
| fld_port_ok | input | 1 | L4 port field present |
| out_vld | output | 1 | Queue ID valid |
| out_miss | output | 1 | Packet unmatched, pass through |
| out_qid | output | 24 | Frame queue ID |
| cfg_err | output | 1 | Configuration rule broken |
| key_addr | output | 32 | Address key field after substitution |
| key_port | output | 32 | Port key field after substitution |

## Verification
The assertions take the scheme configuration as quasi-static. They compare each result against the configuration held in the cycle its input was taken. A configuration that changed in the same cycle as a hash would still be judged against the older settings. The stimulus therefore changes configuration only while in_vld is low and leaves an idle cycle afterwards. The queue range check also depends on out_qid lying outside the mask bits only through the base. The stimulus includes bases that are not aligned to the range, so the checks never assume alignment.

// File: rtl/qd_pkg.sv
package qd_pkg;

  typedef enum logic [1:0] {
    QD_NONE = 2'd0,
    QD_HIT  = 2'd1,
    QD_MISS = 2'd2
  } qd_outcome_e;

endpackage

// File: rtl/qd_cfg_check.sv
module qd_cfg_check #(
  parameter int WW        = 32,
  parameter int QW        = 24,
  parameter int SW        = 6,
  parameter int SHIFT_LSB = 24,
  parameter int EN_BIT    = 31
) (
  input  logic [WW-1:0] mode,
  input  logic [WW-1:0] base,
  input  logic [WW-1:0] hcmd,
  output logic          en,
  output logic          err,
  output logic [SW-1:0] shamt,
  output logic [QW-1:0] mask,
  output logic [QW-1:0] base_q
);
  localparam logic [QW-1:0] ONE = {{(QW-1){1'b0}}, 1'b1};

  logic wide_base;
  logic zero_base;
  logic bad_range;
  logic unused_cfg_bits;

  always_comb begin
    en        = mode[EN_BIT];
    base_q    = base[QW-1:0];
    mask      = hcmd[QW-1:0];
    shamt     = hcmd[SHIFT_LSB +: SW];
    wide_base = |base[WW-1:QW];
    zero_base = (base_q == '0);
    bad_range = |(mask & (mask + ONE));
    err       = wide_base | zero_base | bad_range;
  end

  assign unused_cfg_bits = ^{mode[EN_BIT-1:0], hcmd[WW-1:SHIFT_LSB+SW]};

endmodule

// File: rtl/qd_hash_pick.sv
module qd_hash_pick #(
  parameter int HW = 64,
  parameter int QW = 24,
  parameter int SW = 6
) (
  input  logic [HW-1:0] hash,
  input  logic [SW-1:0] shamt,
  input  logic [QW-1:0] mask,
  input  logic [QW-1:0] base_q,
  output logic [QW-1:0] qid
);
  logic [QW-1:0] window;

  always_comb begin
    window = QW'(hash >> shamt);
    qid    = base_q | (window & mask);
  end

endmodule

// File: rtl/qd_key_subst.sv
module qd_key_subst #(
  parameter int WW   = 32,
  parameter int NKEY = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NKEY-1:0][WW-1:0]   fld,
  input  logic [NKEY-1:0]           fld_ok,
  input  logic [NKEY-1:0][WW-1:0]   dflt,
  output logic [NKEY-1:0][WW-1:0]   key
);
  for (genvar g = 0; g < NKEY; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) key[g] <= '0;
      else     key[g] <= fld_ok[g] ? fld[g] : dflt[g];
    end
  end

endmodule

// File: rtl/hash_qdist.sv
module hash_qdist #(
  parameter int WW        = 32,
  parameter int HW        = 64,
  parameter int QW        = 24,
  parameter int SW        = 6,
  parameter int SHIFT_LSB = 24,
  parameter int EN_BIT    = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WW-1:0] cfg_mode,
  input  logic [WW-1:0] cfg_base,
  input  logic [WW-1:0] cfg_hcmd,
  input  logic [WW-1:0] cfg_dflt_addr,
  input  logic [WW-1:0] cfg_dflt_port,
  input  logic          in_vld,
  input  logic [HW-1:0] in_hash,
  input  logic [WW-1:0] fld_addr,
  input  logic          fld_addr_ok,
  input  logic [WW-1:0] fld_port,
  input  logic          fld_port_ok,
  output logic          out_vld,
  output logic          out_miss,
  output logic [QW-1:0] out_qid,
  output logic          cfg_err,
  output logic [WW-1:0] key_addr,
  output logic [WW-1:0] key_port
);
  import qd_pkg::*;

  localparam int NKEY = 2;

  logic          sch_en;
  logic          sch_err;
  logic [SW-1:0] shamt;
  logic [QW-1:0] mask;
  logic [QW-1:0] base_q;
  logic [QW-1:0] qid_next;
  qd_outcome_e   outcome;

  logic [NKEY-1:0][WW-1:0] kf_fld;
  logic [NKEY-1:0][WW-1:0] kf_dflt;
  logic [NKEY-1:0][WW-1:0] kf_key;
  logic [NKEY-1:0]         kf_ok;

  qd_cfg_check #(
    .WW(WW), .QW(QW), .SW(SW), .SHIFT_LSB(SHIFT_LSB), .EN_BIT(EN_BIT)
  ) i_cfg (
    .mode(cfg_mode), .base(cfg_base), .hcmd(cfg_hcmd),
    .en(sch_en), .err(sch_err), .shamt(shamt), .mask(mask), .base_q(base_q)
  );

  qd_hash_pick #(.HW(HW), .QW(QW), .SW(SW)) i_pick (
    .hash(in_hash), .shamt(shamt), .mask(mask), .base_q(base_q), .qid(qid_next)
  );

  always_comb begin
    if (!in_vld)      outcome = QD_NONE;
    else if (!sch_en) outcome = QD_MISS;
    else if (sch_err) outcome = QD_NONE;
    else              outcome = QD_HIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_miss <= 1'b0;
      out_qid  <= '0;
      cfg_err  <= 1'b0;
    end else begin
      out_vld  <= (outcome == QD_HIT);
      out_miss <= (outcome == QD_MISS);
      cfg_err  <= sch_err;
      if (outcome == QD_HIT) out_qid <= qid_next;
    end
  end

  assign kf_fld  = {fld_port, fld_addr};
  assign kf_dflt = {cfg_dflt_port, cfg_dflt_addr};
  assign kf_ok   = {fld_port_ok, fld_addr_ok};

  qd_key_subst #(.WW(WW), .NKEY(NKEY)) i_key (
    .clk(clk), .rst(rst), .fld(kf_fld), .fld_ok(kf_ok), .dflt(kf_dflt), .key(kf_key)
  );

  assign key_addr = kf_key[0];
  assign key_port = kf_key[1];

  // R9
  out_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_vld, out_miss}));

  // R9
  out_src_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld || out_miss) |-> $past(in_vld));

  // R7
  err_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> !cfg_err);

  // R6
  miss_mode_chk: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> !$past(cfg_mode[EN_BIT]));

  // R2
  qid_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((out_qid & ~$past(cfg_hcmd[QW-1:0])) ==
                 ($past(cfg_base[QW-1:0]) & ~$past(cfg_hcmd[QW-1:0]))));

  // R7
  qid_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_qid != '0));

endmodule

// File: tb/test_hash_qdist.sv
module test_hash_qdist;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_mode = '0, cfg_base = '0, cfg_hcmd = '0;
  logic [31:0] cfg_dflt_addr = 32'h0A0A0A0A, cfg_dflt_port = 32'h0B0B0B0B;
  logic        in_vld = 1'b0;
  logic [63:0] in_hash = '0;
  logic [31:0] fld_addr = '0, fld_port = '0;
  logic        fld_addr_ok = 1'b0, fld_port_ok = 1'b0;
  logic        out_vld, out_miss, cfg_err;
  logic [23:0] out_qid;
  logic [31:0] key_addr, key_port;

  int n_chk = 0;
  int n_fail = 0;
  bit   q_miss[$];
  logic [23:0] q_qid[$];
  string q_tag[$];

  always #4 clk = ~clk;

  hash_qdist i_hash_qdist (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_base(cfg_base), .cfg_hcmd(cfg_hcmd),
    .cfg_dflt_addr(cfg_dflt_addr), .cfg_dflt_port(cfg_dflt_port),
    .in_vld(in_vld), .in_hash(in_hash), .fld_addr(fld_addr), .fld_addr_ok(fld_addr_ok),
    .fld_port(fld_port), .fld_port_ok(fld_port_ok), .out_vld(out_vld), .out_miss(out_miss),
    .out_qid(out_qid), .cfg_err(cfg_err), .key_addr(key_addr), .key_port(key_port)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] calc_qid(logic [63:0] h, logic [31:0] b, logic [31:0] hc);
    logic [63:0] s;
    s = h >> hc[29:24];
    return b[23:0] | (s[23:0] & hc[23:0]);
  endfunction

  function automatic bit calc_err(logic [31:0] b, logic [31:0] hc);
    logic [23:0] m;
    m = hc[23:0];
    return (b[23:0] == 24'd0) || (b[31:24] != 8'd0) || ((m & (m + 24'd1)) != 24'd0);
  endfunction

  task automatic set_cfg(string tag, logic [31:0] md, logic [31:0] b, logic [31:0] hc);
    @(negedge clk);
    cfg_mode = md; cfg_base = b; cfg_hcmd = hc;
    @(negedge clk);
    check({tag, " cfg_err"}, {63'd0, cfg_err}, {63'd0, calc_err(b, hc)});
  endtask

  // drives one hash for one cycle, pushes the expected result if any
  task automatic send(string tag, logic [63:0] h);
    @(negedge clk);
    in_vld = 1'b1; in_hash = h;
    if (!cfg_mode[31]) begin
      q_miss.push_back(1'b1); q_qid.push_back('0); q_tag.push_back(tag);
    end else if (!calc_err(cfg_base, cfg_hcmd)) begin
      q_miss.push_back(1'b0); q_qid.push_back(calc_qid(h, cfg_base, cfg_hcmd)); q_tag.push_back(tag);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && (out_vld || out_miss)) begin
      if (q_miss.size() == 0) begin
        check("R9 unexpected output", {62'd0, out_vld, out_miss}, 64'd0);
      end else begin
        bit m; logic [23:0] e; string t;
        m = q_miss.pop_front(); e = q_qid.pop_front(); t = q_tag.pop_front();
        check({t, " kind"}, {62'd0, out_vld, out_miss}, {62'd0, !m, m});
        if (!m) check({t, " qid"}, {40'd0, out_qid}, {40'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_vld", {63'd0, out_vld}, 0);
    check("R1 out_miss", {63'd0, out_miss}, 0);
    check("R1 cfg_err", {63'd0, cfg_err}, 0);
    check("R1 out_qid", {40'd0, out_qid}, 0);
    check("R1 key_addr", {32'd0, key_addr}, 0);
    check("R1 key_port", {32'd0, key_port}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post out_vld", {63'd0, out_vld}, 0);

    // R2 / R3: shift zero, 16 queues
    set_cfg("R3", 32'h8000_0000, 32'h0000_0100, 32'h0000_000F);
    send("R3 low", 64'hFFFF_FFFF_FF12_3456);
    send("R3 low2", 64'h0000_0000_0000_0009);
    idle();
    // R2: shift 8, 256 queues, unaligned base
    set_cfg("R2", 32'h8000_0000, 32'h0000_1234, 32'h0800_00FF);
    send("R2 s8", 64'hDEAD_BEEF_CAFE_F00D);
    send("R2 s8b", 64'h0123_4567_89AB_CDEF);
    send("R2 s8c", 64'h0);
    idle();
    set_cfg("R2", 32'h8000_0000, 32'h0080_0000, 32'h2800_FFFF + 32'h00FF_0000);
    send("R2 s40", 64'hDEAD_BEEF_CAFE_F00D);
    idle();
    // R3: shift 63
    set_cfg("R3", 32'h8000_0000, 32'h0000_0010, 32'h3F00_0003);
    send("R3 s63 one", 64'h8000_0000_0000_0000);
    send("R3 s63 zero", 64'h7FFF_FFFF_FFFF_FFFF);
    idle();
    // R4: zero command word
    set_cfg("R4", 32'h8000_0000, 32'h00AB_CDEF, 32'h0);
    send("R4 a", 64'hFFFF_FFFF_FFFF_FFFF);
    send("R4 b", 64'h1357_9BDF_2468_ACE0);
    idle();
    // R5: symmetric flag ignored
    set_cfg("R5", 32'h8000_0000, 32'h0000_0400, 32'h4400_03FF);
    send("R5 sym", 64'h0000_0000_0ABC_DEF1);
    idle();
    set_cfg("R5", 32'h8000_0000, 32'h0000_0400, 32'h0400_03FF);
    send("R5 nosym", 64'h0000_0000_0ABC_DEF1);
    idle();
    // R6: disabled scheme
    set_cfg("R6", 32'h7FFF_FFFF, 32'h0000_0100, 32'h0000_000F);
    send("R6 miss", 64'h55);
    idle();
    @(negedge clk);
    check("R6 single pulse", {62'd0, out_vld, out_miss}, 0);
    set_cfg("R6 err", 32'h0, 32'h0, 32'h0000_0005);
    send("R6 miss err", 64'h66);
    idle();
    // R7: error cases
    set_cfg("R7 zero", 32'h8000_0000, 32'h0, 32'h0000_000F);
    send("R7 zero", 64'h1);
    idle();
    check("R7 drop zero", {62'd0, out_vld, out_miss}, 0);
    set_cfg("R7 wide", 32'h8000_0000, 32'h0100_0000, 32'h0000_000F);
    send("R7 wide", 64'h2);
    idle();
    check("R7 drop wide", {62'd0, out_vld, out_miss}, 0);
    set_cfg("R7 range", 32'h8000_0000, 32'h0000_0100, 32'h0000_0005);
    send("R7 range", 64'h3);
    idle();
    check("R7 drop range", {62'd0, out_vld, out_miss}, 0);
    set_cfg("R7 full", 32'h8000_0000, 32'h0000_0001, 32'h00FF_FFFF);
    send("R7 full ok", 64'h0000_0000_0012_3456);
    idle();
    // R9: back-to-back stream
    set_cfg("R9", 32'h8000_0000, 32'h0000_2000, 32'h0C00_0FFF);
    for (int i = 0; i < 8; i++) send("R9 stream", 64'h9E37_79B9_7F4A_7C15 * (i + 1));
    idle();
    repeat (2) @(negedge clk);
    check("R9 queue drained", q_miss.size(), 0);

    // R8: key substitution
    @(negedge clk);
    fld_addr = 32'hC0A8_0001; fld_port = 32'h0000_0050; fld_addr_ok = 1; fld_port_ok = 1;
    @(negedge clk);
    check("R8 addr present", {32'd0, key_addr}, {32'd0, 32'hC0A8_0001});
    check("R8 port present", {32'd0, key_port}, {32'd0, 32'h0000_0050});
    fld_addr_ok = 0;
    @(negedge clk);
    check("R8 addr default", {32'd0, key_addr}, {32'd0, 32'h0A0A_0A0A});
    check("R8 port kept", {32'd0, key_port}, {32'd0, 32'h0000_0050});
    fld_addr_ok = 1; fld_port_ok = 0;
    @(negedge clk);
    check("R8 port default", {32'd0, key_port}, {32'd0, 32'h0B0B_0B0B});
    check("R8 addr back", {32'd0, key_addr}, {32'd0, 32'hC0A8_0001});

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule